// File: doc/BRIEF.md
# DAC Output Serialiser with Deglitch Strobe

This block turns one left and one right parallel sample per output period into the serial stream a pair of DACs expects. A free-running tick counter divides each output period into 64 system-clock ticks. At the first tick of every period the block latches both samples and all its settings. It then sends each channel MSB first on its own data line. The bit clock runs in a single burst of exactly as many pulses as the selected word length, then stays low until the next word start. The word clock toggles at the start of the period and again at its midpoint. Its polarity selects whether a word starts on a falling or a rising edge.

The same tick counter places a deglitch strobe on a grid of 32 slots, each two ticks long, numbered 0 to 31 from the word start. The strobe goes low at the start of one slot and high at the start of another. The slots are either fixed defaults or two programmed 5-bit fields. The counter never stops, so the word clock, the strobe and the bursts continue whatever the sample inputs do.

The serialiser core is a three-state machine. `ST_HALT` keeps the bit clock and data low. `ST_BIT_LO` drives a data bit with the bit clock low. `ST_BIT_HI` holds that bit with the bit clock high. The transitions are as follows:
- `ST_HALT`→`ST_BIT_LO` on the word start, which loads the samples.
- `ST_BIT_LO`→`ST_BIT_HI` always.
- `ST_BIT_HI`→`ST_BIT_LO` while bits remain, shifting both registers.
- `ST_BIT_HI`→`ST_HALT` after the last bit.

A word start forces `ST_BIT_LO` from any state.

Top module: `dac_word_serializer`

## Requirements
- R1: `len_sel` picks the word length, with bit 0 as the lower bit: 2'b00=16, 2'b01=18, 2'b10=20, 2'b11=24. Each period has exactly that many bit-clock rising edges.
- R2: Data goes out MSB first. The transmitted word is the top N bits of the 24-bit sample. Data changes only while the bit clock is low and is stable at each rising edge. Bit k occupies ticks 2k and 2k+1, and the clock is high on the odd tick.
- R3: From tick 2N to tick 63 the bit clock and both data lines stay low. Bursts resume only at the next word start.
- R4: With `wck_pol`=0 the word clock is low for ticks 0–31 and high for ticks 32–63, so a word starts on a falling edge. With `wck_pol`=1 both levels are inverted, so a word starts on a rising edge.
- R5: With `offset_fmt`=0 the word is sent as two's complement. With `offset_fmt`=1 every bit except the word's MSB is inverted.
- R6: With `dg_prog`=0 the strobe falls at the start of slot 14 (tick 28) and rises at the start of slot 30 (tick 60). The programmed fields are ignored.
- R7: With `dg_prog`=1 the strobe falls at tick 2·`dg_fall_slot` and rises at tick 2·`dg_rise_slot`. If the fall slot is later than the rise slot, the low phase wraps over the word start. If both slots are equal, the rise wins and the strobe stays high.
- R8: Samples and settings are latched only at the word start. A change during a period leaves the current word unchanged and takes effect at the next word start.
- R9: During reset the bit clock and both data lines are low, the strobe is high and the word clock is high.
- R10: The left and right lines carry their own samples independently within the same burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, 64 ticks per output period |
| rst_n | input | 1 | Active-low synchronous reset |
| samp_l | input | 24 | Left sample, two's complement, MSB-aligned |
| samp_r | input | 24 | Right sample, two's complement, MSB-aligned |
| len_sel | input | 2 | Word length select |
| offset_fmt | input | 1 | 1 = complementary offset binary output |
| wck_pol | input | 1 | 0 = word starts on falling word-clock edge |
| dg_prog | input | 1 | 1 = use programmed deglitch slots |
| dg_fall_slot | input | 5 | Programmed slot for the strobe's falling edge |
| dg_rise_slot | input | 5 | Programmed slot for the strobe's rising edge |
| bck_o | output | 1 | Burst bit clock |
| wck_o | output | 1 | Word clock |
| dout_l_o | output | 1 | Left serial data |
| dout_r_o | output | 1 | Right serial data |
| dg_o | output | 1 | Deglitch strobe |

## Verification
The bench builds the block with its default parameters: 24-bit samples, 32 deglitch slots and 2 ticks per slot, which gives a 64-tick period. At this size every word length fits in one period, including the 24-bit burst that runs past the word-clock midpoint. Each tick is recorded separately, so exact edge positions are checked for all four lengths, both polarities, the default and wrapped strobe placements, and the equal-slot case. A mid-period change of the length and the samples shows that latching happens only at the word start.

// File: rtl/dws_pkg.sv
package dws_pkg;

    localparam int LEN_W = 5;

    typedef enum logic [1:0] {
        ST_HALT   = 2'd0,
        ST_BIT_LO = 2'd1,
        ST_BIT_HI = 2'd2
    } ser_state_t;

    // Length select: bit 0 is the lower bit.
    function automatic logic [LEN_W-1:0] word_len(input logic [1:0] sel);
        unique case (sel)
            2'b00:   return LEN_W'(16);
            2'b01:   return LEN_W'(18);
            2'b10:   return LEN_W'(20);
            default: return LEN_W'(24);
        endcase
    endfunction

endpackage

// File: rtl/dws_tick_gen.sv
module dws_tick_gen #(
    parameter int PERIOD = 64,
    localparam int TICK_W = $clog2(PERIOD)
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic [TICK_W-1:0] tick_q,
    output logic [TICK_W-1:0] tick_nxt,
    output logic              last
);

    assign last     = (tick_q == TICK_W'(PERIOD - 1));
    assign tick_nxt = last ? '0 : tick_q + 1'b1;

    // Reset parks on the last tick so the first edge starts a word.
    always_ff @(posedge clk) begin
        if (!rst_n) tick_q <= TICK_W'(PERIOD - 1);
        else        tick_q <= tick_nxt;
    end

endmodule

// File: rtl/dws_shift_fsm.sv
module dws_shift_fsm
    import dws_pkg::*;
#(
    parameter int SAMPLE_W = 24
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   start,
    input  logic [LEN_W-1:0]       nbits,
    input  logic                   offset_fmt,
    input  logic [1:0][SAMPLE_W-1:0] samp,
    output logic                   bck,
    output logic [1:0]             dout
);

    ser_state_t           state_q, state_d;
    logic [LEN_W-1:0]     bit_idx_q;
    logic [LEN_W-1:0]     len_q;
    logic [SAMPLE_W-1:0]  sh_q [2];
    logic                 last_bit;

    assign last_bit = (bit_idx_q == len_q - 1'b1);

    // Next-state logic
    always_comb begin
        state_d = state_q;
        if (start) begin
            state_d = ST_BIT_LO;
        end else begin
            unique case (state_q)
                ST_HALT:   state_d = ST_HALT;
                ST_BIT_LO: state_d = ST_BIT_HI;
                ST_BIT_HI: state_d = last_bit ? ST_HALT : ST_BIT_LO;
                default:   state_d = ST_HALT;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_HALT;
        else        state_q <= state_d;
    end

    // Bit counter and captured length
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bit_idx_q <= '0;
            len_q     <= LEN_W'(16);
        end else if (start) begin
            bit_idx_q <= '0;
            len_q     <= nbits;
        end else if (state_q == ST_BIT_HI && state_d == ST_BIT_LO) begin
            bit_idx_q <= bit_idx_q + 1'b1;
        end
    end

    // Per-channel shift registers
    for (genvar ch = 0; ch < 2; ch++) begin : g_chan
        logic [SAMPLE_W-1:0] enc;
        assign enc = offset_fmt
                   ? {samp[ch][SAMPLE_W-1], ~samp[ch][SAMPLE_W-2:0]}
                   : samp[ch];

        always_ff @(posedge clk) begin
            if (!rst_n)
                sh_q[ch] <= '0;
            else if (start)
                sh_q[ch] <= enc;
            else if (state_q == ST_BIT_HI && state_d == ST_BIT_LO)
                sh_q[ch] <= {sh_q[ch][SAMPLE_W-2:0], 1'b0};
        end

        assign dout[ch] = (state_q != ST_HALT) && sh_q[ch][SAMPLE_W-1];
    end

    // Output decode
    always_comb begin
        bck = (state_q == ST_BIT_HI);
    end

    // R2: data does not move on a rising bit-clock edge
    assert_data_stable_at_rise_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bck) |-> $stable(dout));

endmodule

// File: rtl/dws_deglitch.sv
module dws_deglitch #(
    parameter int SLOTS          = 32,
    parameter int TICKS_PER_SLOT = 2,
    localparam int PERIOD = SLOTS * TICKS_PER_SLOT,
    localparam int TICK_W = $clog2(PERIOD),
    localparam int SLOT_W = $clog2(SLOTS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [TICK_W-1:0] tick_nxt,
    input  logic [SLOT_W-1:0] fall_slot,
    input  logic [SLOT_W-1:0] rise_slot,
    output logic              dg_o
);

    logic              slot_begin;
    logic [SLOT_W-1:0] next_slot;

    assign slot_begin = ((int'(tick_nxt) % TICKS_PER_SLOT) == 0);
    assign next_slot  = SLOT_W'(int'(tick_nxt) / TICKS_PER_SLOT);

    // Rise has priority when both slots coincide.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dg_o <= 1'b1;
        end else if (slot_begin) begin
            if (next_slot == rise_slot)      dg_o <= 1'b1;
            else if (next_slot == fall_slot) dg_o <= 1'b0;
        end
    end

endmodule

// File: rtl/dac_word_serializer.sv
module dac_word_serializer
    import dws_pkg::*;
#(
    parameter int SAMPLE_W       = 24,
    parameter int SLOTS          = 32,
    parameter int TICKS_PER_SLOT = 2,
    parameter int DG_FALL_DEF    = 14,
    parameter int DG_RISE_DEF    = 30,
    localparam int SLOT_W = $clog2(SLOTS)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [SAMPLE_W-1:0] samp_l,
    input  logic [SAMPLE_W-1:0] samp_r,
    input  logic [1:0]          len_sel,
    input  logic                offset_fmt,
    input  logic                wck_pol,
    input  logic                dg_prog,
    input  logic [SLOT_W-1:0]   dg_fall_slot,
    input  logic [SLOT_W-1:0]   dg_rise_slot,
    output logic                bck_o,
    output logic                wck_o,
    output logic                dout_l_o,
    output logic                dout_r_o,
    output logic                dg_o
);

    localparam int PERIOD = SLOTS * TICKS_PER_SLOT;
    localparam int HALF   = PERIOD / 2;
    localparam int TICK_W = $clog2(PERIOD);

    logic [TICK_W-1:0]       tick_q, tick_nxt;
    logic                    last;
    logic                    pol_q;
    logic [SLOT_W-1:0]       fall_q, rise_q, fall_eff, rise_eff;
    logic [1:0]              dout;
    logic [1:0][SAMPLE_W-1:0] samp;

    dws_tick_gen #(.PERIOD(PERIOD)) u_tick (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick_q  (tick_q),
        .tick_nxt(tick_nxt),
        .last    (last)
    );

    // Settings are taken only on the edge that starts a word.
    assign fall_eff = !last   ? fall_q
                    : dg_prog ? dg_fall_slot : SLOT_W'(DG_FALL_DEF);
    assign rise_eff = !last   ? rise_q
                    : dg_prog ? dg_rise_slot : SLOT_W'(DG_RISE_DEF);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pol_q  <= 1'b0;
            fall_q <= SLOT_W'(DG_FALL_DEF);
            rise_q <= SLOT_W'(DG_RISE_DEF);
        end else begin
            if (last) pol_q <= wck_pol;
            fall_q <= fall_eff;
            rise_q <= rise_eff;
        end
    end

    assign samp = {samp_r, samp_l};

    dws_shift_fsm #(.SAMPLE_W(SAMPLE_W)) u_ser (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (last),
        .nbits     (word_len(len_sel)),
        .offset_fmt(offset_fmt),
        .samp      (samp),
        .bck       (bck_o),
        .dout      (dout)
    );

    dws_deglitch #(.SLOTS(SLOTS), .TICKS_PER_SLOT(TICKS_PER_SLOT)) u_dg (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick_nxt (tick_nxt),
        .fall_slot(fall_eff),
        .rise_slot(rise_eff),
        .dg_o     (dg_o)
    );

    assign dout_l_o = dout[0];
    assign dout_r_o = dout[1];
    assign wck_o    = (int'(tick_q) < HALF) ? pol_q : ~pol_q;

    // R4: the word clock moves only at the word start or the midpoint
    assert_wck_edges_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wck_o != $past(wck_o)) |-> (tick_q == '0 || int'(tick_q) == HALF));

    // R3: every burst is over before the period wraps
    assert_quiet_at_wrap_R3: assert property (@(posedge clk) disable iff (!rst_n)
        last |-> (!bck_o && !dout_l_o && !dout_r_o));

    // R7: the strobe moves only at a slot boundary that was selected
    assert_dg_on_slot_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (dg_o != $past(dg_o)) |->
            ((int'(tick_q) % TICKS_PER_SLOT) == 0 &&
             (SLOT_W'(int'(tick_q) / TICKS_PER_SLOT) == fall_q ||
              SLOT_W'(int'(tick_q) / TICKS_PER_SLOT) == rise_q)));

    // R1: a burst never starts while the previous one is running
    assert_burst_starts_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_q == '0) |-> !bck_o);

endmodule

// File: tb/tb_dac_word_serializer.sv
module tb_dac_word_serializer;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [23:0] samp_l = '0, samp_r = '0;
    logic [1:0]  len_sel = 2'b00;
    logic        offset_fmt = 1'b0, wck_pol = 1'b0, dg_prog = 1'b0;
    logic [4:0]  dg_fall_slot = '0, dg_rise_slot = '0;
    logic        bck_o, wck_o, dout_l_o, dout_r_o, dg_o;

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;

    logic [63:0] rec_bck, rec_wck, rec_l, rec_r, rec_dg;

    dac_word_serializer dut (
        .clk(clk), .rst_n(rst_n), .samp_l(samp_l), .samp_r(samp_r),
        .len_sel(len_sel), .offset_fmt(offset_fmt), .wck_pol(wck_pol),
        .dg_prog(dg_prog), .dg_fall_slot(dg_fall_slot), .dg_rise_slot(dg_rise_slot),
        .bck_o(bck_o), .wck_o(wck_o), .dout_l_o(dout_l_o), .dout_r_o(dout_r_o),
        .dg_o(dg_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic int len_of(input logic [1:0] sel);
        case (sel)
            2'b00:   return 16;
            2'b01:   return 18;
            2'b10:   return 20;
            default: return 24;
        endcase
    endfunction

    function automatic logic [23:0] enc(input logic [23:0] s, input int n, input bit offs);
        logic [23:0] w;
        w = s >> (24 - n);
        if (offs) w = w ^ ((24'd1 << (n - 1)) - 24'd1);
        return w;
    endfunction

    function automatic bit exp_dg(input int i, input int f, input int r);
        if (f == r) return 1'b1;
        if (f < r)  return !(i >= 2*f && i < 2*r);
        return (i >= 2*r && i < 2*f);
    endfunction

    // Record one full period from its word start; optionally alter inputs mid-word.
    task automatic capture(input bit pol, input int chg_at,
                           input logic [1:0] alt_len, input logic [23:0] alt_l,
                           input logic [23:0] alt_r);
        logic prev;
        int guard = 0;
        prev = wck_o;
        @(negedge clk);
        while (!(prev != pol && wck_o == pol) && guard < 400) begin
            prev = wck_o;
            @(negedge clk);
            guard++;
        end
        for (int i = 0; i < 64; i++) begin
            rec_bck[i] = bck_o; rec_wck[i] = wck_o;
            rec_l[i] = dout_l_o; rec_r[i] = dout_r_o; rec_dg[i] = dg_o;
            if (i == chg_at) begin
                len_sel = alt_len; samp_l = alt_l; samp_r = alt_r;
            end
            if (i < 63) @(negedge clk);
        end
    endtask

    task automatic check_period(input string tag, input int n, input bit pol,
                                input bit offs, input int f, input int r,
                                input logic [23:0] sl, input logic [23:0] sr);
        logic [23:0] gl = '0, gr = '0;
        int rises = 0, moved = 0, noisy = 0, wbad = 0, dbad = 0;
        for (int i = 1; i < 64; i++) begin
            if (rec_bck[i] && !rec_bck[i-1]) begin
                rises++;
                gl = {gl[22:0], rec_l[i]};
                gr = {gr[22:0], rec_r[i]};
                if (rec_l[i] != rec_l[i-1] || rec_r[i] != rec_r[i-1]) moved++;
            end
        end
        for (int i = 2*n; i < 64; i++)
            if (rec_bck[i] || rec_l[i] || rec_r[i]) noisy++;
        for (int i = 0; i < 64; i++) begin
            if (rec_wck[i] != ((i < 32) ? pol : !pol)) wbad++;
            if (rec_dg[i] != exp_dg(i, f, r)) dbad++;
        end
        chk(rises == n, "R1", {tag, " rising edges"}, rises, n);
        chk(moved == 0, "R2", {tag, " data moved at rise"}, moved, 0);
        chk(gl == enc(sl, n, offs), offs ? "R5" : "R2", {tag, " left word"}, gl, enc(sl, n, offs));
        chk(gr == enc(sr, n, offs), "R10", {tag, " right word"}, gr, enc(sr, n, offs));
        chk(noisy == 0, "R3", {tag, " halt activity"}, noisy, 0);
        chk(wbad == 0, "R4", {tag, " word clock ticks wrong"}, wbad, 0);
        chk(dbad == 0, (f == 14 && r == 30) ? "R6" : "R7", {tag, " strobe ticks wrong"}, dbad, 0);
    endtask

    // Apply settings, let one period settle, then check the next.
    task automatic run_case(input string tag, input logic [1:0] ls, input bit offs,
                            input bit pol, input bit prog, input int f, input int r,
                            input logic [23:0] sl, input logic [23:0] sr);
        len_sel = ls; offset_fmt = offs; wck_pol = pol; dg_prog = prog;
        dg_fall_slot = 5'(f); dg_rise_slot = 5'(r); samp_l = sl; samp_r = sr;
        capture(pol, -1, ls, sl, sr);
        capture(pol, -1, ls, sl, sr);
        check_period(tag, len_of(ls), pol, offs, prog ? f : 14, prog ? r : 30, sl, sr);
    endtask

    task automatic t_reset();
        repeat (3) @(negedge clk);
        chk(bck_o == 1'b0, "R9", "reset bck", bck_o, 0);
        chk(dout_l_o == 1'b0 && dout_r_o == 1'b0, "R9", "reset data", {dout_l_o, dout_r_o}, 0);
        chk(dg_o == 1'b1, "R9", "reset strobe", dg_o, 1);
        chk(wck_o == 1'b1, "R9", "reset word clock", wck_o, 1);
        rst_n = 1'b1;
    endtask

    task automatic t_lengths();
        run_case("len16", 2'b00, 0, 0, 0, 0, 0, 24'hA5C3_96, 24'h3C_0F_F0);
        run_case("len18", 2'b01, 0, 0, 0, 0, 0, 24'h12_34_56, 24'hFE_DC_BA);
        run_case("len20", 2'b10, 0, 0, 0, 0, 0, 24'h80_00_01, 24'h7F_FF_FE);
        run_case("len24", 2'b11, 0, 0, 0, 0, 0, 24'hC0_FF_EE, 24'h0B_AD_01);
    endtask

    task automatic t_offset();
        run_case("offs_neg", 2'b11, 1, 0, 0, 0, 0, 24'h80_00_00, 24'hFF_FF_FF);
        run_case("offs_pos", 2'b00, 1, 0, 0, 0, 0, 24'h7F_FF_00, 24'h00_00_00);
    endtask

    task automatic t_polarity();
        run_case("pol1", 2'b10, 0, 1, 0, 0, 0, 24'h5A_5A_5A, 24'hA5_A5_A5);
        run_case("pol0", 2'b00, 0, 0, 0, 0, 0, 24'h01_02_03, 24'h04_05_06);
    endtask

    task automatic t_dg_default();
        run_case("dg_def", 2'b00, 0, 0, 0, 3, 7, 24'h11_11_11, 24'h22_22_22);
    endtask

    task automatic t_dg_prog();
        run_case("dg_3_20", 2'b11, 0, 0, 1, 3, 20, 24'h33_33_33, 24'h44_44_44);
        run_case("dg_wrap", 2'b01, 0, 0, 1, 25, 5, 24'h55_55_55, 24'h66_66_66);
        run_case("dg_eq", 2'b00, 0, 0, 1, 9, 9, 24'h77_77_77, 24'h88_88_88);
        run_case("dg_edge", 2'b00, 0, 0, 1, 0, 31, 24'h99_99_99, 24'hAA_AA_AA);
    endtask

    task automatic t_latch();
        len_sel = 2'b00; offset_fmt = 0; wck_pol = 0; dg_prog = 0;
        samp_l = 24'hF0_0F_0F; samp_r = 24'h0F_F0_F0;
        capture(0, -1, 2'b00, samp_l, samp_r);
        capture(0, 6, 2'b11, 24'h13_57_9B, 24'h24_68_AC);
        check_period("R8_mid", 16, 0, 0, 14, 30, 24'hF0_0F_0F, 24'h0F_F0_F0);
        capture(0, -1, 2'b11, samp_l, samp_r);
        check_period("R8_next", 24, 0, 0, 14, 30, 24'h13_57_9B, 24'h24_68_AC);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    endtask

    initial begin
        t_reset();
        t_lengths();
        t_offset();
        t_polarity();
        t_dg_default();
        t_dg_prog();
        t_latch();
        finish_run();
    end

    initial begin
        repeat (150000) @(posedge clk);
        tests++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

endmodule